// File: doc/BRIEF.md
# Byte-Level I2C Master with Register Control

This block is an I2C bus master that moves one byte for each command. Software loads a byte into the data register. It then sets the transfer bit in the control register, and may set start, stop and acknowledge-select bits in the same write. The block drives SCL and SDA as open-drain lines: each output is a pull-low enable, and the resolved line levels come back on two inputs. When the byte is finished the block clears the transfer bit. It also raises a sticky completion flag, which software clears by writing a one to that flag's bit.

The SCL rate comes from an external tick. Each SCL half-period lasts a fixed number of ticks, and a control bit selects between a standard count and a fast count. A line monitor follows start and stop conditions on the bus and reports whether the bus is busy. A unit-reset bit, honoured only while the unit is disabled, returns the block to idle.

The register port is a plain synchronous bus. A write takes effect on the clock edge where `bus_wr` is high, and the read data is a combinational function of `bus_addr`. There is no back-pressure on this port. Software learns when a transfer has finished by polling the transfer bit or the flags.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the control, status and data registers read 0, and neither SCL nor SDA is pulled low.
- R2: Register offsets are: line monitor 0x00 (bit0 SCL, bit1 SDA), data 0x08 (bits 7:0), control 0x10, status 0x18, own address 0x20 (bits 6:0, read back as written).
- R3: Control bits are: 0 start, 1 stop, 2 send-NAK, 3 transfer, 5 SCL drive enable, 6 unit enable, 14 unit reset, 15 fast. Writing transfer=1 with start=1 sends a start condition and then the data byte MSB first. The transfer bit reads 1 until the byte (and any stop) is done, then reads 0, and status bit2 (unit busy) is 0 again.
- R4: After a transmitted byte that the slave acknowledges, status bit6 (transmit empty) is 1 and status bit1 (received ACK/NAK) is 0.
- R5: If a transmitted byte is NAKed, status bit1 is 1 and status bit10 (bus error) is set. Status bit6 is also set.
- R6: Status bit3 (bus busy) is 1 after a start condition on the lines. With stop=1 the block sends a stop condition after the acknowledge bit, and bit3 returns to 0.
- R7: The direction is taken from bit0 of a byte sent with start=1 and shows in status bit0 (1 = read). Later transfers without start then receive a byte: it is latched into the data register, and status bit7 (receive full) is set.
- R8: In a receive transfer, the block drives ACK (SDA low) in the acknowledge slot when send-NAK is 0, and releases SDA (NAK) when send-NAK is 1.
- R9: Status bits 6, 7 and 10 stay set until a write to the status register with a 1 in that bit position. Writing 0x7FF clears all three.
- R10: An SCL high phase lasts 8 ticks in standard mode and 2 ticks in fast mode.
- R11: While unit enable is 0, a write that sets the transfer bit has no effect: the bit stays 0 and the lines stay released.
- R12: Setting unit reset with unit enable 0 aborts any transfer. It clears the transfer bit, unit busy, bus busy and the sticky flags, and releases both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Bit-timing tick from a divider |
| bus_addr | input | 6 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |

## Verification
A behavioural slave on the modelled open-drain lines acknowledges or refuses bytes and supplies read data from a queue. A write address followed by a data byte with stop shows whether start, MSB-first shifting and the stop condition are correct. A refused address separates the ACK path from the NAK and bus-error path. A read address followed by an ACKed byte and a NAKed byte shows that direction tracking, receive latching and the master's acknowledge choice are each honoured. SCL high times are measured in both rate modes, and transfers attempted while disabled or cut short by unit reset show that the lines stay released.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  // register selects (byte address bits 5:3)
  localparam logic [2:0] RS_MON  = 3'd0;
  localparam logic [2:0] RS_DATA = 3'd1;
  localparam logic [2:0] RS_CTRL = 3'd2;
  localparam logic [2:0] RS_STAT = 3'd3;
  localparam logic [2:0] RS_OWN  = 3'd4;

  // control bit positions
  localparam int CB_START = 0;
  localparam int CB_STOP  = 1;
  localparam int CB_NAK   = 2;
  localparam int CB_XFER  = 3;
  localparam int CB_SCLEN = 5;
  localparam int CB_UEN   = 6;
  localparam int CB_URST  = 14;
  localparam int CB_FAST  = 15;

  // status bit positions that software clears by writing one
  localparam int SB_TXE = 6;
  localparam int SB_RXF = 7;
  localparam int SB_ERR = 10;

  typedef enum logic [3:0] {
    EN_IDLE, EN_ST0, EN_ST1, EN_ST2,
    EN_BLO, EN_BHI,
    EN_PLO, EN_PHI, EN_PEND
  } eng_state_t;
endpackage

// File: rtl/i2c_bm_busmon.sv
module i2c_bm_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic scl,
  input  logic sda,
  output logic busy
);
  logic p_scl, p_sda;
  logic seen_start, seen_stop;

  assign seen_start = scl && p_scl && p_sda && !sda;
  assign seen_stop  = scl && p_scl && !p_sda && sda;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_scl <= 1'b1;
      p_sda <= 1'b1;
      busy  <= 1'b0;
    end else begin
      p_scl <= scl;
      p_sda <= sda;
      if (clr || seen_stop) busy <= 1'b0;
      else if (seen_start)  busy <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
  import i2c_bm_pkg::*;
#(
  parameter int HALF_STD  = 8,
  parameter int HALF_FAST = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       fast,
  input  logic       go,
  input  logic       go_start,
  input  logic       go_stop,
  input  logic       go_nak,
  input  logic       go_rx,
  input  logic [7:0] tx_byte,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low,
  output logic       busy,
  output logic       done,
  output logic       done_rx,
  output logic [7:0] rx_byte,
  output logic       ack_bit
);
  localparam int HMAX = (HALF_STD > HALF_FAST) ? HALF_STD : HALF_FAST;
  localparam int CW   = $clog2(HMAX + 1);

  eng_state_t    st;
  logic [CW-1:0] hcnt;
  logic [CW-1:0] half_m1;
  logic [3:0]    bidx;
  logic [7:0]    tsh, rsh;
  logic          hold, l_stop, l_nak, l_rx, ack_q;
  logic          adv, half_end, in_data;

  assign half_m1  = fast ? CW'(HALF_FAST - 1) : CW'(HALF_STD - 1);
  // a high phase only counts while the line is really high (stretching)
  assign adv      = tick && (st != EN_BHI || scl_in);
  assign half_end = adv && (hcnt == half_m1);
  assign in_data  = (bidx < 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= EN_IDLE; hcnt <= '0; bidx <= '0; tsh <= '0; rsh <= '0;
      hold <= 1'b0; l_stop <= 1'b0; l_nak <= 1'b0; l_rx <= 1'b0;
      ack_q <= 1'b0; done <= 1'b0;
    end else if (clr) begin
      st <= EN_IDLE; hcnt <= '0; bidx <= '0; tsh <= '0; rsh <= '0;
      hold <= 1'b0; l_stop <= 1'b0; l_nak <= 1'b0; l_rx <= 1'b0;
      ack_q <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == EN_IDLE)  hcnt <= '0;
      else if (half_end)  hcnt <= '0;
      else if (adv)       hcnt <= hcnt + 1'b1;

      unique case (st)
        EN_IDLE: if (go) begin
          tsh    <= tx_byte;
          l_stop <= go_stop;
          l_nak  <= go_nak;
          l_rx   <= go_rx && !go_start;
          bidx   <= '0;
          st     <= go_start ? EN_ST0 : EN_BLO;
        end
        EN_ST0:  if (half_end) st <= EN_ST1;
        EN_ST1:  if (half_end) st <= EN_ST2;
        EN_ST2:  if (half_end) st <= EN_BLO;
        EN_BLO:  if (half_end) st <= EN_BHI;
        EN_BHI:  if (half_end) begin
          if (in_data) begin
            if (l_rx) rsh <= {rsh[6:0], sda_in};
            else      tsh <= {tsh[6:0], 1'b0};
            bidx <= bidx + 1'b1;
            st   <= EN_BLO;
          end else begin
            if (!l_rx) ack_q <= sda_in;
            if (l_stop) st <= EN_PLO;
            else begin
              st   <= EN_IDLE;
              hold <= 1'b1;
              done <= 1'b1;
            end
          end
        end
        EN_PLO:  if (half_end) st <= EN_PHI;
        EN_PHI:  if (half_end) st <= EN_PEND;
        EN_PEND: if (half_end) begin
          st   <= EN_IDLE;
          hold <= 1'b0;
          done <= 1'b1;
        end
        default: st <= EN_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    unique case (st)
      EN_IDLE: scl_low = hold;
      EN_ST0:  scl_low = 1'b1;
      EN_ST2:  sda_low = 1'b1;
      EN_BLO, EN_BHI: begin
        scl_low = (st == EN_BLO);
        if (in_data) sda_low = !l_rx && !tsh[7];
        else         sda_low = l_rx && !l_nak;
      end
      EN_PLO:  begin scl_low = 1'b1; sda_low = 1'b1; end
      EN_PHI:  sda_low = 1'b1;
      default: ;
    endcase
  end

  assign busy    = (st != EN_IDLE);
  assign done_rx = l_rx;
  assign rx_byte = rsh;
  assign ack_bit = ack_q;
endmodule

// File: rtl/i2c_bm_regs.sv
module i2c_bm_regs
  import i2c_bm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        line_scl,
  input  logic        line_sda,
  input  logic        bus_busy,
  input  logic        eng_busy,
  input  logic        eng_done,
  input  logic        eng_done_rx,
  input  logic [7:0]  eng_rx_byte,
  input  logic        eng_ack,
  output logic        go,
  output logic        go_start,
  output logic        go_stop,
  output logic        go_nak,
  output logic        go_rx,
  output logic [7:0]  tx_byte,
  output logic        fast,
  output logic        scl_en,
  output logic        unit_en,
  output logic        soft_rst,
  output logic        ctrl_tb,
  output logic        flag_tx,
  output logic        flag_err
);
  logic [15:0] ctrl_q;
  logic [7:0]  data_q;
  logic [6:0]  own_q;
  logic        rw_q, ackst_q, fl_rx;
  logic        at_word, wr_data, wr_ctrl, wr_stat, wr_own;
  logic [2:0]  sel;
  logic        unused_hi;

  assign unused_hi = ^bus_wdata[31:16];
  assign sel     = bus_addr[5:3];
  assign at_word = (bus_addr[2:0] == 3'd0);
  assign wr_data = bus_wr && at_word && sel == RS_DATA;
  assign wr_ctrl = bus_wr && at_word && sel == RS_CTRL;
  assign wr_stat = bus_wr && at_word && sel == RS_STAT;
  assign wr_own  = bus_wr && at_word && sel == RS_OWN;

  assign soft_rst = ctrl_q[CB_URST] && !ctrl_q[CB_UEN];
  assign unit_en  = ctrl_q[CB_UEN];
  assign go       = wr_ctrl && bus_wdata[CB_XFER] && unit_en && !soft_rst
                    && !ctrl_q[CB_XFER] && !eng_busy;
  assign go_start = bus_wdata[CB_START];
  assign go_stop  = bus_wdata[CB_STOP];
  assign go_nak   = bus_wdata[CB_NAK];
  assign go_rx    = rw_q;
  assign tx_byte  = data_q;
  assign fast     = ctrl_q[CB_FAST];
  assign scl_en   = ctrl_q[CB_SCLEN];
  assign ctrl_tb  = ctrl_q[CB_XFER];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; data_q <= '0; own_q <= '0;
      rw_q <= 1'b0; ackst_q <= 1'b0;
      flag_tx <= 1'b0; fl_rx <= 1'b0; flag_err <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q[15:4] <= bus_wdata[15:4];
        ctrl_q[2:0]  <= bus_wdata[2:0];
      end
      if (wr_own)  own_q  <= bus_wdata[6:0];
      if (wr_data) data_q <= bus_wdata[7:0];

      if (soft_rst) begin
        ctrl_q[CB_XFER] <= 1'b0;
        rw_q <= 1'b0; ackst_q <= 1'b0;
        flag_tx <= 1'b0; fl_rx <= 1'b0; flag_err <= 1'b0;
      end else begin
        ctrl_q[CB_XFER] <= go || (ctrl_q[CB_XFER] && !eng_done);
        if (go && go_start) rw_q <= data_q[0];
        if (wr_stat) begin
          if (bus_wdata[SB_TXE]) flag_tx  <= 1'b0;
          if (bus_wdata[SB_RXF]) fl_rx    <= 1'b0;
          if (bus_wdata[SB_ERR]) flag_err <= 1'b0;
        end
        if (eng_done) begin
          if (eng_done_rx) begin
            data_q <= eng_rx_byte;
            fl_rx  <= 1'b1;
          end else begin
            flag_tx <= 1'b1;
            ackst_q <= eng_ack;
            if (eng_ack) flag_err <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (at_word) begin
      unique case (sel)
        RS_MON:  bus_rdata = {30'd0, line_sda, line_scl};
        RS_DATA: bus_rdata = {24'd0, data_q};
        RS_CTRL: bus_rdata = {16'd0, ctrl_q};
        RS_STAT: bus_rdata = {21'd0, flag_err, 2'b00, fl_rx, flag_tx, 2'b00,
                              bus_busy, eng_busy, ackst_q, rw_q};
        RS_OWN:  bus_rdata = {25'd0, own_q};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int HALF_STD  = 8,
  parameter int HALF_FAST = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [5:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_drive_low,
  output logic        sda_drive_low
);
  logic       go, go_start, go_stop, go_nak, go_rx, fast, scl_en, unit_en;
  logic       soft_rst, ctrl_tb, flag_tx, flag_err, bus_busy;
  logic       eng_busy, eng_done, eng_done_rx, eng_ack, eng_scl_low, eng_sda_low;
  logic [7:0] tx_byte, eng_rx_byte;

  i2c_bm_regs u_regs (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
    .line_scl(scl_in), .line_sda(sda_in), .bus_busy,
    .eng_busy, .eng_done, .eng_done_rx, .eng_rx_byte, .eng_ack,
    .go, .go_start, .go_stop, .go_nak, .go_rx, .tx_byte, .fast, .scl_en,
    .unit_en, .soft_rst, .ctrl_tb, .flag_tx, .flag_err
  );

  i2c_bm_engine #(.HALF_STD(HALF_STD), .HALF_FAST(HALF_FAST)) u_eng (
    .clk, .rst_n, .clr(soft_rst), .tick, .fast,
    .go, .go_start, .go_stop, .go_nak, .go_rx, .tx_byte,
    .scl_in, .sda_in,
    .scl_low(eng_scl_low), .sda_low(eng_sda_low),
    .busy(eng_busy), .done(eng_done), .done_rx(eng_done_rx),
    .rx_byte(eng_rx_byte), .ack_bit(eng_ack)
  );

  i2c_bm_busmon u_mon (
    .clk, .rst_n, .clr(soft_rst), .scl(scl_in), .sda(sda_in), .busy(bus_busy)
  );

  assign scl_drive_low = eng_scl_low && scl_en;
  assign sda_drive_low = eng_sda_low;
endmodule

// File: rtl/i2c_bm_chk.sv
module i2c_bm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        unit_en,
  input logic        eng_busy,
  input logic        eng_done,
  input logic        eng_done_rx,
  input logic        eng_ack,
  input logic        ctrl_tb,
  input logic        flag_tx,
  input logic        flag_err,
  input logic        bus_wr,
  input logic [5:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        scl_drive_low,
  input logic        sda_drive_low
);
  logic clr_tx;
  assign clr_tx = bus_wr && bus_addr == 6'h18 && bus_wdata[6];

  a_r11_idle_while_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!unit_en && !eng_busy) |=> !eng_busy);

  a_r3_xfer_bit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !ctrl_tb);

  a_r4_txe_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !eng_done_rx && !soft_rst) |=> flag_tx);

  a_r5_nak_raises_err: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !eng_done_rx && eng_ack && !soft_rst) |=> flag_err);

  a_r9_w1c_txe: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tx && !eng_done) |=> !flag_tx);

  a_r12_reset_idles: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!eng_busy && !ctrl_tb && !flag_tx && !flag_err
                  && !scl_drive_low && !sda_drive_low));
endmodule

bind i2c_byte_master i2c_bm_chk u_chk (
  .clk, .rst_n, .soft_rst, .unit_en, .eng_busy, .eng_done, .eng_done_rx,
  .eng_ack, .ctrl_tb, .flag_tx, .flag_err, .bus_wr, .bus_addr, .bus_wdata,
  .scl_drive_low, .sda_drive_low
);

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
  localparam int HS = 8;
  localparam int HF = 2;
  localparam int TDIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        scl_dl, sda_dl;
  logic        scl_l, sda_l;

  int vecs = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // slave model state
  logic       s_sda_low, s_active, s_tx, s_tx_pend, s_addr, s_mack, p_scl, p_sda;
  logic [3:0] s_cnt;
  logic [7:0] s_sh, s_txb;
  bit         s_nak_mode = 1'b0;
  logic [7:0] s_rxq[$];
  logic [7:0] s_txq[$];

  assign scl_l = !scl_dl;
  assign sda_l = !(sda_dl || s_sda_low);

  i2c_byte_master #(.HALF_STD(HS), .HALF_FAST(HF)) dut (
    .clk, .rst_n, .tick, .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .scl_in(scl_l), .sda_in(sda_l),
    .scl_drive_low(scl_dl), .sda_drive_low(sda_dl)
  );

  always @(posedge clk) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= !tick;
  end

  // behavioural slave on the wired-AND lines
  always @(posedge clk) begin
    logic [7:0] nb;
    p_scl <= scl_l;
    p_sda <= sda_l;
    if (!rst_n) begin
      s_sda_low <= 1'b0; s_active <= 1'b0; s_tx <= 1'b0; s_tx_pend <= 1'b0;
      s_addr <= 1'b0; s_mack <= 1'b0; s_cnt <= '0; s_sh <= '0; s_txb <= '0;
      p_scl <= 1'b1; p_sda <= 1'b1;
    end else if (scl_l && p_scl && p_sda && !sda_l) begin
      s_active <= 1'b1; s_cnt <= '0; s_addr <= 1'b1; s_tx <= 1'b0;
      s_tx_pend <= 1'b0; s_sda_low <= 1'b0;
    end else if (scl_l && p_scl && !p_sda && sda_l) begin
      s_active <= 1'b0; s_tx <= 1'b0; s_sda_low <= 1'b0;
    end else if (s_active && scl_l && !p_scl) begin
      if (s_cnt < 4'd8) begin
        if (!s_tx) s_sh <= {s_sh[6:0], sda_l};
        s_cnt <= s_cnt + 1'b1;
      end else if (s_cnt == 4'd8) begin
        s_mack <= sda_l;
        s_cnt  <= 4'd9;
      end
    end else if (s_active && !scl_l && p_scl) begin
      if (s_cnt == 4'd8) begin
        if (!s_tx) begin
          s_rxq.push_back(s_sh);
          s_sda_low <= !s_nak_mode;
          if (s_addr) s_tx_pend <= s_sh[0] && !s_nak_mode;
          s_addr <= 1'b0;
        end else s_sda_low <= 1'b0;
      end else if (s_cnt == 4'd9) begin
        s_cnt <= '0;
        s_sda_low <= 1'b0;
        if (s_tx_pend || (s_tx && !s_mack)) begin
          nb = s_txq.pop_front();
          s_txb <= nb;
          s_sda_low <= !nb[7];
          s_tx <= 1'b1;
          s_tx_pend <= 1'b0;
        end else s_tx <= 1'b0;
      end else if (s_tx && s_cnt >= 4'd1 && s_cnt <= 4'd7) begin
        s_sda_low <= !s_txb[3'(4'd7 - s_cnt)];
      end
    end
  end

  // SCL high-phase width measurement
  int hc = 0;
  int minw = 100000;
  bit mclr = 1'b0;
  always @(posedge clk) begin
    if (scl_l) hc <= hc + 1;
    else begin
      if (hc != 0 && hc < minw) minw <= hc;
      hc <= 0;
    end
    if (mclr) minw <= 100000;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic wait_xfer(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rreg(6'h10, v);
      if (!v[3]) return;
    end
    chk(tag, 32'hDEAD, 32'h0);
  endtask

  task automatic clr_min();
    @(negedge clk); mclr = 1'b1;
    @(negedge clk); mclr = 1'b0;
  endtask

  task automatic slave_byte(input string tag, input logic [7:0] exp);
    logic [7:0] b;
    if (s_rxq.size() == 0) chk(tag, 32'hEEEE, {24'd0, exp});
    else begin b = s_rxq.pop_front(); chk(tag, {24'd0, b}, {24'd0, exp}); end
  endtask

  initial begin
    logic [31:0] v;
    s_txq.push_back(8'hC3);
    s_txq.push_back(8'h5A);
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    rreg(6'h10, v); chk("R1 control after reset", v, 32'h0);
    rreg(6'h18, v); chk("R1 status after reset", v, 32'h0);
    rreg(6'h08, v); chk("R1 data after reset", v, 32'h0);
    chk("R1 lines released", {30'd0, scl_dl, sda_dl}, 32'h0);

    // R2: monitor and own address
    rreg(6'h00, v); chk("R2 monitor idle lines", v, 32'h3);
    wreg(6'h20, 32'h55); rreg(6'h20, v); chk("R2 own address readback", v, 32'h55);

    // R11: transfer request while disabled
    wreg(6'h08, 32'hA4);
    wreg(6'h10, 32'h09);
    repeat (60) @(negedge clk);
    rreg(6'h10, v); chk("R11 transfer bit stays 0", v, 32'h01);
    chk("R11 lines stay released", {30'd0, scl_dl, sda_dl}, 32'h0);
    chk("R11 slave saw nothing", s_rxq.size(), 0);

    // R3/R4/R6: write address with start, no stop
    wreg(6'h10, 32'h60);
    clr_min();
    wreg(6'h10, 32'h69);
    rreg(6'h18, v); chk("R3 unit busy during transfer", {31'd0, v[2]}, 32'h1);
    wait_xfer("R3 transfer timeout");
    rreg(6'h10, v); chk("R3 transfer bit self-cleared", v, 32'h61);
    slave_byte("R3 slave got address byte", 8'hA4);
    rreg(6'h18, v); chk("R4 R6 status after acked start byte", v, 32'h048);
    chk("R10 standard SCL high width", minw, HS * TDIV);

    // R6: data byte with stop
    wreg(6'h08, 32'h5B);
    wreg(6'h10, 32'h6A);
    wait_xfer("R6 transfer timeout");
    slave_byte("R6 slave got data byte", 8'h5B);
    rreg(6'h18, v); chk("R6 bus busy clear after stop", v, 32'h040);
    chk("R6 lines released after stop", {30'd0, scl_dl, sda_dl}, 32'h0);

    // R9: clear all
    wreg(6'h18, 32'h7FF);
    rreg(6'h18, v); chk("R9 flags cleared", v, 32'h0);

    // R5: NAK on address
    s_nak_mode = 1'b1;
    wreg(6'h08, 32'h30);
    wreg(6'h10, 32'h6B);
    wait_xfer("R5 transfer timeout");
    slave_byte("R5 slave saw byte", 8'h30);
    rreg(6'h18, v); chk("R5 NAK status", v, 32'h442);
    wreg(6'h18, 32'h400);
    rreg(6'h18, v); chk("R9 only bus error cleared", v, 32'h042);
    wreg(6'h18, 32'h7FF);
    rreg(6'h18, v); chk("R9 sticky flags cleared", v, 32'h002);
    s_nak_mode = 1'b0;

    // R7/R8: read address, then ACKed and NAKed receive
    wreg(6'h08, 32'hA5);
    wreg(6'h10, 32'h69);
    wait_xfer("R7 address timeout");
    slave_byte("R7 slave got read address", 8'hA5);
    rreg(6'h18, v); chk("R7 read direction status", v, 32'h049);
    wreg(6'h18, 32'h7FF);
    wreg(6'h10, 32'h68);
    wait_xfer("R7 receive timeout");
    rreg(6'h08, v); chk("R7 first received byte", v, 32'hC3);
    rreg(6'h18, v); chk("R7 receive full", v, 32'h089);
    chk("R8 master sent ACK", {31'd0, s_mack}, 32'h0);
    wreg(6'h18, 32'h7FF);
    wreg(6'h10, 32'h6E);
    wait_xfer("R8 receive timeout");
    rreg(6'h08, v); chk("R7 second received byte", v, 32'h5A);
    chk("R8 master sent NAK", {31'd0, s_mack}, 32'h1);
    rreg(6'h18, v); chk("R6 R7 status after final read", v, 32'h081);
    wreg(6'h18, 32'h7FF);

    // R10: fast mode
    wreg(6'h08, 32'h10);
    wreg(6'h10, 32'h8060);
    clr_min();
    wreg(6'h10, 32'h806B);
    wait_xfer("R10 fast timeout");
    slave_byte("R10 slave got fast byte", 8'h10);
    chk("R10 fast SCL high width", minw, HF * TDIV);

    // R12: unit reset mid-transfer
    wreg(6'h08, 32'h77);
    wreg(6'h10, 32'h69);
    repeat (25) @(negedge clk);
    rreg(6'h18, v); chk("R12 busy before reset", {31'd0, v[2]}, 32'h1);
    wreg(6'h10, 32'h4000);
    repeat (3) @(negedge clk);
    rreg(6'h10, v); chk("R12 transfer bit cleared", v, 32'h4000);
    rreg(6'h18, v); chk("R12 status idle", v, 32'h0);
    chk("R12 lines released", {30'd0, scl_dl, sda_dl}, 32'h0);
    wreg(6'h10, 32'h60);
    wreg(6'h08, 32'hA4);
    wreg(6'h10, 32'h6B);
    wait_xfer("R12 recovery timeout");
    slave_byte("R12 transfer after reset", 8'hA4);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vecs++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule